// File: doc/BRIEF.md
# Dual-Motor H-Bridge PWM Driver

This block drives two DC motors through an H-bridge that has two control pins per motor. A free-running prescaler on the 50 MHz system clock supplies a time base: the rising edge of one of its bits becomes a single-cycle tick every 2.56 µs. A phase counter steps once per tick through a fixed period of 195 ticks, which gives a PWM rate of about 2.003 kHz. For each motor, the 8-bit duty word is compared with the phase to produce the pulse. The pulse sets the motor's speed.

A direction bit per motor picks which of the two bridge pins carries the pulse. The other pin is held low. The direction bit is sampled only at the start of a PWM period, so a pin never carries a cut-short pulse. A global enable forces all bridge pins low within one clock. Every output is a register in the system clock domain.

Top module: `motor_pwm_drive`

## Requirements
- R1: While reset is high, and after its release until the first tick, all four bridge pins are low.
- R2: The tick recurs every 128 system clocks (2.56 µs at 50 MHz), taken from the rising edge of prescaler bit 6.
- R3: A PWM period lasts 195 ticks (24960 clocks), and every pulse starts at the beginning of a period.
- R4: For a duty word d with 1 ≤ d ≤ 194, the active pin is high for the first d ticks of each period, that is for d × 128 clocks, and low for the rest of the period.
- R5: A duty word of 0 keeps both pins of that motor low.
- R6: A duty word of 195 or more keeps the active pin high for the whole period.
- R7: For motor m, direction bit 0 sends the pulse to `fwdPin[m]` and holds `revPin[m]` low. Direction bit 1 does the reverse. The two pins of one motor are never high at the same time.
- R8: A direction change takes effect only at the next period start. The pulse already in progress finishes at full width on the old pin.
- R9: When enable is low, all bridge pins are low from the next clock on. Once enable returns high, output resumes at the next tick.
- R10: The two motors are independent. Each uses its own duty field (bits [7:0] for motor 0, bits [15:8] for motor 1) and its own direction bit (bit m).
- R11: A duty change takes effect at the next tick, without waiting for a period start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Global drive enable; when low, all pins go low |
| dutyIn | input | 16 | Packed duty words, motor m in bits [8m+7:8m] |
| dirIn | input | 2 | Direction per motor: 0 forward pin, 1 reverse pin |
| fwdPin | output | 2 | Forward bridge pin per motor |
| revPin | output | 2 | Reverse bridge pin per motor |

## Verification
The assertions assume that the duty, direction and enable inputs are synchronous to the system clock and may change on any cycle. They do not require the inputs to be held between ticks. The properties on pin stability therefore exempt only the tick cycle and the enable-low cycle.

The bench changes its inputs only on falling clock edges. It lets each new setting settle for two full periods before it measures pin high time over a window of exactly one period. The one exception is the direction test, which flips direction on purpose in the middle of a pulse to check the period-start sampling.

The main instance runs with a shortened prescaler so that each period is quick to measure. A second instance keeps the default parameters and confirms the 128-clock tick and the 24960-clock period.

// File: rtl/motor_pwm_pkg.sv
package motor_pwm_pkg;
  // Strobes from the time-base control to the per-motor datapath
  typedef struct packed {
    logic tick;         // one-cycle pulse per PWM slot
    logic periodStart;  // tick on which a new period begins (phase goes to 0)
  } strobe_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import motor_pwm_pkg::*;
#(
  parameter int TAP_BIT      = 6,
  parameter int PERIOD_TICKS = 195,
  parameter int CNT_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  output strobe_t          strb,
  output logic [CNT_W-1:0] phaseNext
);
  localparam int PRESC_W = TAP_BIT + 1;
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(PERIOD_TICKS - 1);

  logic [PRESC_W-1:0] prescCount;
  logic               tapPrev;
  logic [CNT_W-1:0]   phaseCount;
  logic               lastSlot;

  always_ff @(posedge clk) begin
    if (rst) begin
      prescCount <= '0;
      tapPrev    <= 1'b0;
    end else begin
      prescCount <= prescCount + 1'b1;
      tapPrev    <= prescCount[TAP_BIT];
    end
  end

  assign lastSlot         = (phaseCount == LAST_SLOT);
  assign strb.tick        = prescCount[TAP_BIT] & ~tapPrev;
  assign strb.periodStart = strb.tick & lastSlot;
  assign phaseNext        = lastSlot ? '0 : phaseCount + 1'b1;

  // Phase starts on the last slot, so the first tick opens a period
  always_ff @(posedge clk) begin
    if (rst)            phaseCount <= LAST_SLOT;
    else if (strb.tick) phaseCount <= phaseNext;
  end

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    strb.tick |=> !strb.tick);
  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phaseCount <= LAST_SLOT);
  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.tick |=> $stable(phaseCount));
endmodule

// File: rtl/motor_bridge.sv
module motor_bridge
  import motor_pwm_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  strobe_t           strb,
  input  logic [CNT_W-1:0]  phaseNext,
  input  logic [DUTY_W-1:0] duty,
  input  logic              dir,
  output logic              fwdPin,
  output logic              revPin
);
  logic dirHeld;
  logic dirUse;
  logic pulseOn;

  assign dirUse  = strb.periodStart ? dir : dirHeld;
  assign pulseOn = int'(duty) > int'(phaseNext);

  always_ff @(posedge clk) begin
    if (rst) dirHeld <= 1'b0;
    else if (strb.periodStart) dirHeld <= dir;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      fwdPin <= 1'b0;
      revPin <= 1'b0;
    end else if (strb.tick) begin
      fwdPin <= pulseOn & ~dirUse;
      revPin <= pulseOn & dirUse;
    end
  end

  // R7
  pins_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(fwdPin && revPin));
  // R8
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.periodStart |=> $stable(dirHeld));
  // R9
  enable_off_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!fwdPin && !revPin));
  // R11
  pin_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !strb.tick) |=> ($stable(fwdPin) && $stable(revPin)));
endmodule

// File: rtl/motor_pwm_drive.sv
module motor_pwm_drive
  import motor_pwm_pkg::*;
#(
  parameter int NUM_MOTORS   = 2,
  parameter int DUTY_W       = 8,
  parameter int TAP_BIT      = 6,
  parameter int PERIOD_TICKS = 195
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         enable,
  input  logic [NUM_MOTORS*DUTY_W-1:0] dutyIn,
  input  logic [NUM_MOTORS-1:0]        dirIn,
  output logic [NUM_MOTORS-1:0]        fwdPin,
  output logic [NUM_MOTORS-1:0]        revPin
);
  localparam int CNT_W = $clog2(PERIOD_TICKS);

  strobe_t          strb;
  logic [CNT_W-1:0] phaseNext;

  pwm_timebase #(
    .TAP_BIT(TAP_BIT), .PERIOD_TICKS(PERIOD_TICKS), .CNT_W(CNT_W)
  ) i_timebase (
    .clk(clk), .rst(rst), .strb(strb), .phaseNext(phaseNext)
  );

  for (genvar m = 0; m < NUM_MOTORS; m++) begin : g_motor
    motor_bridge #(.DUTY_W(DUTY_W), .CNT_W(CNT_W)) i_bridge (
      .clk(clk), .rst(rst), .enable(enable), .strb(strb),
      .phaseNext(phaseNext),
      .duty(dutyIn[m*DUTY_W +: DUTY_W]),
      .dir(dirIn[m]),
      .fwdPin(fwdPin[m]), .revPin(revPin[m])
    );
  end

  // R1
  reset_low_chk: assert property (@(posedge clk)
    $past(rst) |-> (fwdPin == '0 && revPin == '0));
endmodule

// File: tb/test_motor_pwm_drive.sv
module test_motor_pwm_drive;
  localparam int TAP_FAST = 2;
  localparam int TCLK     = 8;          // clocks per tick with TAP_FAST
  localparam int PTICKS   = 195;
  localparam int PCLK     = PTICKS * TCLK;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [15:0] dutyIn = '0;
  logic [1:0]  dirIn = '0;
  logic [1:0]  fwdPin, revPin;
  logic [1:0]  fwdFull, revFull;
  int nChecks = 0;
  int nFails = 0;
  bit fullDone = 1'b0;

  always #10 clk = ~clk;

  motor_pwm_drive #(.TAP_BIT(TAP_FAST)) i_motor_pwm_drive (
    .clk(clk), .rst(rst), .enable(enable), .dutyIn(dutyIn), .dirIn(dirIn),
    .fwdPin(fwdPin), .revPin(revPin)
  );

  motor_pwm_drive i_motor_pwm_drive_full (
    .clk(clk), .rst(rst), .enable(1'b1), .dutyIn(16'h0061), .dirIn(2'b00),
    .fwdPin(fwdFull), .revPin(revFull)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count high cycles per pin over exactly one period
  task automatic measure(output int f0, output int r0, output int f1, output int r1);
    f0 = 0; r0 = 0; f1 = 0; r1 = 0;
    for (int i = 0; i < PCLK; i++) begin
      @(negedge clk);
      f0 += int'(fwdPin[0]); r0 += int'(revPin[0]);
      f1 += int'(fwdPin[1]); r1 += int'(revPin[1]);
    end
  endtask

  task automatic settle();
    repeat (2 * PCLK) @(negedge clk);
  endtask

  task automatic test_reset();
    rst = 1'b1; enable = 1'b1; dutyIn = 16'hFFFF;
    repeat (5) @(negedge clk);
    check("R1 pins in reset", int'({fwdPin, revPin}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pins before first tick", int'({fwdPin, revPin}), 0);
  endtask

  task automatic test_duty(input int d0, input bit dr0, input int d1, input bit dr1,
                           input string req);
    int f0, r0, f1, r1, on0, on1;
    dutyIn = {8'(d1), 8'(d0)}; dirIn = {dr1, dr0};
    settle();
    measure(f0, r0, f1, r1);
    on0 = ((d0 >= PTICKS) ? PTICKS : d0) * TCLK;
    on1 = ((d1 >= PTICKS) ? PTICKS : d1) * TCLK;
    check({req, " R7 m0 fwd"}, f0, dr0 ? 0 : on0);
    check({req, " R7 m0 rev"}, r0, dr0 ? on0 : 0);
    check({req, " R10 m1 fwd"}, f1, dr1 ? 0 : on1);
    check({req, " R10 m1 rev"}, r1, dr1 ? on1 : 0);
  endtask

  task automatic test_dir_change();
    int t, highA;
    bit seen;
    dutyIn = {8'd10, 8'd100}; dirIn = 2'b00;
    settle();
    seen = 1'b0;
    for (int i = 0; i < 2 * PCLK && !seen; i++) begin
      @(negedge clk);
      if (fwdPin[0]) seen = 1'b1;
    end
    // first high sample: period start of motor 0
    t = 0; highA = 1;
    while (!revPin[0] && t < 2 * PCLK) begin
      if (t == 20) dirIn[0] = 1'b1;
      @(negedge clk);
      t++;
      highA += int'(fwdPin[0]);
    end
    check("R8 old pulse full width", highA, 100 * TCLK);
    check("R8 new pin starts at period start", t, PCLK);
  endtask

  task automatic test_enable();
    int f0, r0, f1, r1;
    dutyIn = {8'd150, 8'd150}; dirIn = 2'b10; enable = 1'b1;
    settle();
    while (!fwdPin[0]) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R9 pins low one clock after disable", int'({fwdPin, revPin}), 0);
    measure(f0, r0, f1, r1);
    check("R9 no drive while disabled", f0 + r0 + f1 + r1, 0);
    enable = 1'b1;
    test_duty(150, 1'b0, 150, 1'b1, "R9 resume");
  endtask

  task automatic test_duty_update();
    int t;
    // duty rises mid-period: pin must rise at the next tick, not the next period
    dutyIn = {8'd0, 8'd0}; dirIn = 2'b00;
    settle();
    repeat (PCLK / 2) @(negedge clk);
    dutyIn[7:0] = 8'd255;
    t = 0;
    while (!fwdPin[0] && t < 2 * PCLK) begin
      @(negedge clk);
      t++;
    end
    check("R11 duty change within one tick", int'(t <= TCLK), 1);
  endtask

  // Default-parameter instance: tick and period timing at full scale
  initial begin : full_scale
    int t, w;
    wait (!rst);
    while (!fwdFull[0]) @(negedge clk);
    while (fwdFull[0]) @(negedge clk);
    while (!fwdFull[0]) @(negedge clk);
    t = 0; w = 0;
    while (fwdFull[0]) begin @(negedge clk); t++; w++; end
    while (!fwdFull[0]) begin @(negedge clk); t++; end
    check("R2 high width 97 ticks of 128 clocks", w, 97 * 128);
    check("R3 full period clocks", t, 24960);
    check("R7 full reverse pin idle", int'(revFull[0]), 0);
    fullDone = 1'b1;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    test_reset();
    test_duty(50, 1'b0, 120, 1'b1, "R4");
    test_duty(0, 1'b1, 1, 1'b0, "R5");
    test_duty(195, 1'b0, 255, 1'b1, "R6");
    test_duty(194, 1'b1, 0, 1'b0, "R4 max-partial");
    test_dir_change();
    test_enable();
    test_duty_update();
    wait (fullDone);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule